// File: doc/BRIEF.md
# 8-bit ALU with Status Flags

This block is the arithmetic and logic datapath of a small 8-bit processor core. Each cycle it takes one operation code, a first operand, and a second operand chosen between a register value and an immediate. It computes an 8-bit result and a write-back strobe at once, with no register on the way. It also computes the next value of an 8-bit status word.

The status word is held in a register inside the block. Its current value feeds carry-in, sticky zero and the bits that an operation leaves alone. When `op_valid` is high the status register loads the new flags at the clock edge. Each operation class updates only its own subset of flags. Compares produce flags without asking for a write-back. A pair of single-bit operations set or clear any status bit picked by a 3-bit index.

The status bits, from bit 7 down to bit 0, are: interrupt-enable, transfer bit, half carry (H), signed (S), overflow (V), negative (N), zero (Z) and carry (C). Unary operations act on `opnd_a`.

Top module: `flagged_alu8`

## Requirements
- R1: The status register resets to 0x00. When `op_valid` is high it takes `next_flags` at the rising clock edge; when `op_valid` is low it holds. Status bits: 7 interrupt-enable, 6 transfer, 5 H, 4 S, 3 V, 2 N, 1 Z, 0 C.
- R2: When `use_imm` is 1 the second operand is `imm`; when it is 0 the second operand is `opnd_b`.
- R3: Add (code 0) gives A+B and add-with-carry (code 1) gives A+B+C. Both set H from the carry out of bit 3, C from the carry out of bit 7, V on signed overflow, and Z and N from the result.
- R4: Subtract (code 2) gives A-B and subtract-with-carry (code 3) gives A-B-C. C and H are the borrows out of bit 7 and bit 3, and V is set on signed overflow. For code 3 the new Z is 1 only when the result is zero and the old Z was 1.
- R5: Compare (code 4) and compare-with-carry (code 5) set flags exactly as codes 2 and 3 do, and hold `wr_en` low.
- R6: AND (6), OR (7) and XOR (8) clear V and update Z and N. They leave H and C unchanged.
- R7: Ones' complement (9) gives 0xFF-A with C=1 and V=0. Two's complement (10) gives 0x00-A and updates H, C and V as a subtraction from zero.
- R8: Increment (11) and decrement (12) update Z, N and V. V is set when increment starts at 0x7F or decrement starts at 0x80. C and H are unchanged.
- R9: The shifts are: left shift (13) and right shift (14), which insert 0; rotate left (15) and rotate right (16), which insert the old C; and arithmetic right shift (17), which keeps bit 7. C gets the bit shifted out, V = N xor C, Z and N follow the result, and H is unchanged.
- R10: Nibble swap (18) exchanges bits 7..4 with bits 3..0 of A and leaves every flag unchanged.
- R11: Flag set (19) and flag clear (20) force the status bit numbered by `flag_idx` to 1 or 0. They change no other bit and hold `wr_en` low.
- R12: For codes 0 to 17, S equals N xor V. Bits 7 and 6 change only through codes 19 and 20.
- R13: Codes 21 to 31 hold `wr_en` low and leave `next_flags` equal to the status. `wr_en` is low whenever `op_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation present; status loads at the edge |
| opcode | input | 5 | Operation code |
| opnd_a | input | 8 | First operand |
| opnd_b | input | 8 | Second operand from the register side |
| use_imm | input | 1 | Selects `imm` as second operand |
| imm | input | 8 | Immediate second operand |
| flag_idx | input | 3 | Status bit index for flag set/clear |
| result | output | 8 | Computed result |
| wr_en | output | 1 | Write-back request |
| next_flags | output | 8 | Status value after this operation |
| status | output | 8 | Current status register |

## Verification
The bench targets the carry and overflow boundaries: 0x0F+0x01 for half carry, 0x7F+0x01 and 0x80-0x01 for signed overflow, and 0xFF+0x01 for carry with zero. A wrong carry chain or overflow formula shows up there as a missing or extra H, V or C. Sticky zero is tested by a chained subtract-with-carry after both a zero and a nonzero earlier step. A design that recomputes Z plainly would report equality on a multi-byte value whose upper byte alone matches. It also targets two's complement of 0x00 and 0x80, increment and decrement across their overflow points with carry held, rotates that must pull in the old carry, and flag set/clear on every index. A design that wrote back on compare, touched carry on increment, or let an unused code disturb status would give a wrong strobe or a wrong status word.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int DW  = 8;
  localparam int HN  = DW / 2;
  localparam int MSB = DW - 1;

  localparam int FL_C = 0;
  localparam int FL_Z = 1;
  localparam int FL_N = 2;
  localparam int FL_V = 3;
  localparam int FL_S = 4;
  localparam int FL_H = 5;

  typedef enum logic [4:0] {
    OP_ADD = 5'd0,  OP_ADC = 5'd1,  OP_SUB = 5'd2,  OP_SBC = 5'd3,
    OP_CMP = 5'd4,  OP_CPC = 5'd5,  OP_AND = 5'd6,  OP_OR  = 5'd7,
    OP_XOR = 5'd8,  OP_COM = 5'd9,  OP_NEG = 5'd10, OP_INC = 5'd11,
    OP_DEC = 5'd12, OP_LSL = 5'd13, OP_LSR = 5'd14, OP_ROL = 5'd15,
    OP_ROR = 5'd16, OP_ASR = 5'd17, OP_SWP = 5'd18, OP_FST = 5'd19,
    OP_FCL = 5'd20
  } alu_op_e;

  typedef struct packed {
    logic [DW-1:0] res;
    logic          c;
    logic          h;
    logic          v;
  } arith_t;

  function automatic arith_t add_core(logic [DW-1:0] a, logic [DW-1:0] b, logic cin);
    arith_t o;
    logic [DW:0] s;
    logic [HN:0] lo;
    s  = {1'b0, a} + {1'b0, b} + {{DW{1'b0}}, cin};
    lo = {1'b0, a[HN-1:0]} + {1'b0, b[HN-1:0]} + {{HN{1'b0}}, cin};
    o.res = s[DW-1:0];
    o.c   = s[DW];
    o.h   = lo[HN];
    o.v   = (a[MSB] == b[MSB]) && (s[MSB] != a[MSB]);
    return o;
  endfunction

  function automatic arith_t sub_core(logic [DW-1:0] a, logic [DW-1:0] b, logic bin);
    arith_t o;
    logic [DW:0] s;
    logic [HN:0] lo;
    s  = {1'b0, a} - {1'b0, b} - {{DW{1'b0}}, bin};
    lo = {1'b0, a[HN-1:0]} - {1'b0, b[HN-1:0]} - {{HN{1'b0}}, bin};
    o.res = s[DW-1:0];
    o.c   = s[DW];
    o.h   = lo[HN];
    o.v   = (a[MSB] != b[MSB]) && (s[MSB] != a[MSB]);
    return o;
  endfunction
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
(
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output arith_t        out
);
  localparam logic [DW-1:0] ONE  = DW'(1);
  localparam logic [DW-1:0] ZERO = '0;

  always_comb begin
    case (op)
      OP_ADD:         out = add_core(a, b, 1'b0);
      OP_ADC:         out = add_core(a, b, cin);
      OP_SUB, OP_CMP: out = sub_core(a, b, 1'b0);
      OP_SBC, OP_CPC: out = sub_core(a, b, cin);
      OP_NEG:         out = sub_core(ZERO, a, 1'b0);
      OP_INC:         out = add_core(a, ONE, 1'b0);
      OP_DEC:         out = sub_core(a, ONE, 1'b0);
      default:        out = '0;
    endcase
  end
endmodule

// File: rtl/alu8_bitops.sv
module alu8_bitops
  import alu8_pkg::*;
(
  input  alu_op_e       op,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          shout
);
  logic [DW-1:0] swapped;

  genvar g;
  generate
    for (g = 0; g < HN; g++) begin : g_swap
      assign swapped[g]      = a[g + HN];
      assign swapped[g + HN] = a[g];
    end
  endgenerate

  always_comb begin
    shout = 1'b0;
    case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_COM:  res = ~a;
      OP_LSL:  begin res = {a[MSB-1:0], 1'b0};   shout = a[MSB]; end
      OP_ROL:  begin res = {a[MSB-1:0], cin};    shout = a[MSB]; end
      OP_LSR:  begin res = {1'b0, a[MSB:1]};     shout = a[0];   end
      OP_ROR:  begin res = {cin, a[MSB:1]};      shout = a[0];   end
      OP_ASR:  begin res = {a[MSB], a[MSB:1]};   shout = a[0];   end
      OP_SWP:  res = swapped;
      default: res = '0;
    endcase
  end
endmodule

// File: rtl/alu8_status_reg.sv
module alu8_status_reg
  import alu8_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    q <= '0;
    else if (load) q <= d;
  end
endmodule

// File: rtl/flagged_alu8.sv
module flagged_alu8
  import alu8_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       op_valid,
  input  logic [4:0] opcode,
  input  logic [7:0] opnd_a,
  input  logic [7:0] opnd_b,
  input  logic       use_imm,
  input  logic [7:0] imm,
  input  logic [2:0] flag_idx,
  output logic [7:0] result,
  output logic       wr_en,
  output logic [7:0] next_flags,
  output logic [7:0] status
);
  alu_op_e       op;
  logic [DW-1:0] b_sel;
  arith_t        ar;
  logic [DW-1:0] bo_res;
  logic          bo_shout;
  logic [DW-1:0] nf;
  logic [DW-1:0] res_c;
  logic          upd_nz, is_shift, sticky_z, writes_back;
  logic          zero_res;

  assign op    = alu_op_e'(opcode);
  assign b_sel = use_imm ? imm : opnd_b;

  alu8_arith u_arith (
    .op(op), .a(opnd_a), .b(b_sel), .cin(status[FL_C]), .out(ar)
  );

  alu8_bitops u_bitops (
    .op(op), .a(opnd_a), .b(b_sel), .cin(status[FL_C]),
    .res(bo_res), .shout(bo_shout)
  );

  always_comb begin
    nf          = status;
    res_c       = '0;
    upd_nz      = 1'b0;
    is_shift    = 1'b0;
    sticky_z    = 1'b0;
    writes_back = 1'b0;
    case (op)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_CPC, OP_NEG: begin
        res_c       = ar.res;
        nf[FL_H]    = ar.h;
        nf[FL_V]    = ar.v;
        nf[FL_C]    = ar.c;
        upd_nz      = 1'b1;
        sticky_z    = (op == OP_SBC) || (op == OP_CPC);
        writes_back = (op != OP_CMP) && (op != OP_CPC);
      end
      OP_INC, OP_DEC: begin
        res_c = ar.res; nf[FL_V] = ar.v; upd_nz = 1'b1; writes_back = 1'b1;
      end
      OP_AND, OP_OR, OP_XOR: begin
        res_c = bo_res; nf[FL_V] = 1'b0; upd_nz = 1'b1; writes_back = 1'b1;
      end
      OP_COM: begin
        res_c = bo_res; nf[FL_V] = 1'b0; nf[FL_C] = 1'b1;
        upd_nz = 1'b1; writes_back = 1'b1;
      end
      OP_LSL, OP_LSR, OP_ROL, OP_ROR, OP_ASR: begin
        res_c = bo_res; nf[FL_C] = bo_shout; is_shift = 1'b1;
        upd_nz = 1'b1; writes_back = 1'b1;
      end
      OP_SWP: begin
        res_c = bo_res; writes_back = 1'b1;
      end
      OP_FST: nf[flag_idx] = 1'b1;
      OP_FCL: nf[flag_idx] = 1'b0;
      default: ;
    endcase
    zero_res = (res_c == '0);
    if (upd_nz) begin
      nf[FL_N] = res_c[MSB];
      nf[FL_Z] = sticky_z ? (zero_res && status[FL_Z]) : zero_res;
      if (is_shift) nf[FL_V] = nf[FL_N] ^ nf[FL_C];
      nf[FL_S] = nf[FL_N] ^ nf[FL_V];
    end
  end

  assign result     = res_c;
  assign wr_en      = op_valid && writes_back;
  assign next_flags = nf;

  alu8_status_reg u_sreg (
    .clk(clk), .rst_n(rst_n), .load(op_valid), .d(nf), .q(status)
  );
endmodule

// File: rtl/alu8_flags_chk.sv
module alu8_flags_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic [4:0] opcode,
  input logic       wr_en,
  input logic [7:0] next_flags,
  input logic [7:0] status
);
  assert_status_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> status == $past(next_flags));
  assert_status_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(status));
  assert_cmp_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == 5'd4 || opcode == 5'd5) |-> !wr_en);
  assert_logic_v_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode >= 5'd6 && opcode <= 5'd9) |-> !next_flags[3]);
  assert_incdec_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == 5'd11 || opcode == 5'd12) |->
      (next_flags[0] == status[0] && next_flags[5] == status[5]));
  assert_swap_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
    opcode == 5'd18 |-> next_flags == status);
  assert_flagop_nowrite_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (opcode == 5'd19 || opcode == 5'd20) |-> !wr_en);
  assert_sign_rule_R12: assert property (@(posedge clk) disable iff (!rst_n)
    opcode <= 5'd17 |-> next_flags[4] == (next_flags[2] ^ next_flags[3]));
  assert_top_bits_R12: assert property (@(posedge clk) disable iff (!rst_n)
    opcode <= 5'd18 |-> next_flags[7:6] == status[7:6]);
  assert_unused_code_R13: assert property (@(posedge clk) disable iff (!rst_n)
    opcode >= 5'd21 |-> (!wr_en && next_flags == status));
  assert_idle_nowrite_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> !wr_en);
endmodule

bind flagged_alu8 alu8_flags_chk u_flags_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
  .wr_en(wr_en), .next_flags(next_flags), .status(status)
);

// File: tb/tb_flagged_alu8.sv
module tb_flagged_alu8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] opcode = '0;
  logic [7:0] opnd_a = '0, opnd_b = '0, imm = '0;
  logic       use_imm = 1'b0;
  logic [2:0] flag_idx = '0;
  logic [7:0] result, next_flags, status;
  logic       wr_en;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  flagged_alu8 dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .use_imm(use_imm), .imm(imm),
    .flag_idx(flag_idx), .result(result), .wr_en(wr_en),
    .next_flags(next_flags), .status(status)
  );

  typedef struct packed {
    logic       chk_res;
    logic [7:0] res;
    logic       wr;
    logic [7:0] nf;
    logic [7:0] st;
  } exp_t;

  exp_t  exp_q[$];
  string tag_q[$];
  event  drv_ev;
  logic [7:0] model_st = '0;

  function automatic int sx(logic [7:0] v);
    return v[7] ? int'(v) - 256 : int'(v);
  endfunction

  function automatic logic [16:0] ref_calc(int op, logic [7:0] a, logic [7:0] b,
                                           logic [7:0] fl, logic [2:0] idx);
    logic [7:0] r = '0;
    logic [7:0] f = fl;
    logic w = 1'b0;
    int ci, d, sv;
    case (op)
      0, 1: begin
        ci = (op == 1) ? int'(fl[0]) : 0;
        d = int'(a) + int'(b) + ci; r = d[7:0];
        f[0] = d > 255; f[5] = (int'(a % 16) + int'(b % 16) + ci) > 15;
        sv = sx(a) + sx(b) + ci; f[3] = sv > 127 || sv < -128;
        f[1] = r == 0; w = 1'b1;
      end
      2, 3, 4, 5: begin
        ci = (op == 3 || op == 5) ? int'(fl[0]) : 0;
        d = int'(a) - int'(b) - ci; r = d[7:0];
        f[0] = d < 0; f[5] = (int'(a % 16) - int'(b % 16) - ci) < 0;
        sv = sx(a) - sx(b) - ci; f[3] = sv > 127 || sv < -128;
        f[1] = (op == 3 || op == 5) ? (r == 0 && fl[1]) : (r == 0);
        w = op < 4;
      end
      6, 7, 8: begin
        r = (op == 6) ? (a & b) : (op == 7) ? (a | b) : (a ^ b);
        f[3] = 1'b0; f[1] = r == 0; w = 1'b1;
      end
      9:  begin r = 8'd255 - a; f[0] = 1'b1; f[3] = 1'b0; f[1] = r == 0; w = 1'b1; end
      10: begin
        d = 0 - int'(a); r = d[7:0]; f[0] = a != 0; f[5] = (a % 16) != 0;
        f[3] = a == 8'h80; f[1] = r == 0; w = 1'b1;
      end
      11: begin r = a + 8'd1; f[3] = a == 8'h7F; f[1] = r == 0; w = 1'b1; end
      12: begin r = a - 8'd1; f[3] = a == 8'h80; f[1] = r == 0; w = 1'b1; end
      13, 14, 15, 16, 17: begin
        case (op)
          13: begin r = a << 1;              f[0] = a[7]; end
          14: begin r = a >> 1;              f[0] = a[0]; end
          15: begin r = {a[6:0], fl[0]};     f[0] = a[7]; end
          16: begin r = {fl[0], a[7:1]};     f[0] = a[0]; end
          default: begin r = {a[7], a[7:1]}; f[0] = a[0]; end
        endcase
        f[1] = r == 0; f[3] = r[7] ^ f[0]; w = 1'b1;
      end
      18: begin r = {a[3:0], a[7:4]}; w = 1'b1; end
      19: f[idx] = 1'b1;
      20: f[idx] = 1'b0;
      default: ;
    endcase
    if (op <= 17) begin
      f[2] = r[7];
      f[4] = f[2] ^ f[3];
    end
    return {w, r, f};
  endfunction

  task automatic drive(input logic v, input int op, input logic [7:0] a,
                       input logic [7:0] b, input logic ui, input logic [7:0] im,
                       input logic [2:0] idx, input string tag);
    exp_t e;
    logic [16:0] rc;
    logic [7:0] b_eff;
    @(negedge clk);
    op_valid = v; opcode = op[4:0]; opnd_a = a; opnd_b = b;
    use_imm = ui; imm = im; flag_idx = idx;
    b_eff = ui ? im : b;
    rc = ref_calc(op, a, b_eff, model_st, idx);
    e.wr = v && rc[16];
    e.chk_res = rc[16];
    e.res = rc[15:8];
    e.nf  = rc[7:0];
    e.st  = model_st;
    exp_q.push_back(e);
    tag_q.push_back(tag);
    if (v) model_st = rc[7:0];
    ->drv_ev;
  endtask

  task automatic cmp8(input string tag, input string what,
                      input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s %s: got %h expected %h", tag, what, got, exp);
    end
  endtask

  initial begin : monitor
    exp_t e;
    string t;
    forever begin
      @(drv_ev);
      #2;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      cmp8(t, "status", status, e.st);
      cmp8(t, "next_flags", next_flags, e.nf);
      cmp8(t, "wr_en", {7'd0, wr_en}, {7'd0, e.wr});
      if (e.chk_res) cmp8(t, "result", result, e.res);
    end
  end

  initial begin : watchdog
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    cmp8("R1", "reset status", status, 8'h00);
    rst_n = 1'b1;
    // R3 add and add-with-carry boundaries
    drive(1, 0, 8'h0F, 8'h01, 0, 0, 0, "R3");
    drive(1, 0, 8'h7F, 8'h01, 0, 0, 0, "R3");
    drive(1, 0, 8'hFF, 8'h01, 0, 0, 0, "R3");
    drive(1, 1, 8'h10, 8'h20, 0, 0, 0, "R3");
    drive(1, 1, 8'h80, 8'h80, 0, 0, 0, "R3");
    // R2 immediate operand selection
    drive(1, 0, 8'h11, 8'hEE, 1, 8'h22, 0, "R2");
    drive(1, 2, 8'h50, 8'h00, 1, 8'h50, 0, "R2");
    // R4 subtract and sticky-zero chain
    drive(1, 2, 8'h80, 8'h01, 0, 0, 0, "R4");
    drive(1, 2, 8'h00, 8'h01, 0, 0, 0, "R4");
    drive(1, 3, 8'h10, 8'h0F, 0, 0, 0, "R4");
    drive(1, 2, 8'h05, 8'h05, 0, 0, 0, "R4");
    drive(1, 3, 8'h33, 8'h33, 0, 0, 0, "R4");
    drive(1, 2, 8'h06, 8'h05, 0, 0, 0, "R4");
    drive(1, 3, 8'h33, 8'h33, 0, 0, 0, "R4");
    // R5 compares: flags only, no write
    drive(1, 4, 8'h12, 8'h34, 0, 0, 0, "R5");
    drive(1, 4, 8'h44, 8'h44, 0, 0, 0, "R5");
    drive(1, 5, 8'h44, 8'h44, 0, 0, 0, "R5");
    drive(1, 0, 8'hFF, 8'h02, 0, 0, 0, "R5");
    drive(1, 5, 8'h44, 8'h43, 0, 0, 0, "R5");
    // R6 logic ops
    drive(1, 6, 8'hF0, 8'h0F, 0, 0, 0, "R6");
    drive(1, 7, 8'h80, 8'h01, 0, 0, 0, "R6");
    drive(1, 8, 8'hAA, 8'hAA, 0, 0, 0, "R6");
    // R7 complements
    drive(1, 9, 8'hFF, 0, 0, 0, 0, "R7");
    drive(1, 9, 8'h12, 0, 0, 0, 0, "R7");
    drive(1, 10, 8'h00, 0, 0, 0, 0, "R7");
    drive(1, 10, 8'h80, 0, 0, 0, 0, "R7");
    drive(1, 10, 8'h08, 0, 0, 0, 0, "R7");
    // R8 increment and decrement around overflow, carry kept
    drive(1, 11, 8'h7F, 0, 0, 0, 0, "R8");
    drive(1, 11, 8'hFF, 0, 0, 0, 0, "R8");
    drive(1, 12, 8'h80, 0, 0, 0, 0, "R8");
    drive(1, 12, 8'h01, 0, 0, 0, 0, "R8");
    // R9 shifts and rotates
    drive(1, 13, 8'h81, 0, 0, 0, 0, "R9");
    drive(1, 15, 8'h40, 0, 0, 0, 0, "R9");
    drive(1, 14, 8'h01, 0, 0, 0, 0, "R9");
    drive(1, 16, 8'h02, 0, 0, 0, 0, "R9");
    drive(1, 17, 8'h81, 0, 0, 0, 0, "R9");
    drive(1, 16, 8'h80, 0, 0, 0, 0, "R9");
    // R10 swap keeps flags
    drive(1, 18, 8'hA5, 0, 0, 0, 0, "R10");
    // R11 flag set/clear on every index, R12 top bits only via these
    for (int i = 0; i < 8; i++) drive(1, 19, 0, 0, 0, 0, i[2:0], "R11");
    drive(1, 0, 8'h01, 8'h01, 0, 0, 0, "R12");
    for (int i = 0; i < 8; i++) drive(1, 20, 0, 0, 0, 0, i[2:0], "R11");
    drive(1, 19, 0, 0, 0, 0, 3'd7, "R12");
    drive(1, 12, 8'h00, 0, 0, 0, 0, "R12");
    // R13 unused codes and idle cycles; R1 hold when not valid
    drive(1, 25, 8'h12, 8'h34, 0, 0, 0, "R13");
    drive(1, 31, 8'hFF, 8'hFF, 0, 0, 0, "R13");
    drive(0, 0, 8'hFF, 8'h01, 0, 0, 0, "R1");
    drive(0, 20, 0, 0, 0, 0, 3'd7, "R1");
    drive(0, 0, 0, 0, 0, 0, 0, "R1");
    @(negedge clk);
    #4;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule